// File: doc/BRIEF.md
# I/O Expander Register Write Engine

This block is a serial-bus master that writes registers inside 16-bit SPI-attached I/O expander chips. A client presents one request: an operation code, the index of the target expander, a register address and a 16-bit data word. The block turns the request into one or two write frames. Each frame is three bytes long: the fixed write opcode, then the register address, then the value. A frame goes out while only the target expander's select line is held low.

Besides the plain single-register write, the block runs three short sequences. One sets both port directions of an expander so that its pins drive or float. One places a 16-bit bus address across the two output ports of an expander. One sets the data port to drive and then writes a byte to it. The serial clock comes from the system clock through a divider parameter. It idles low, and every select stays high for at least one full serial clock period between frames. A `done` pulse marks the end of each request.

Top module: `xpdr_spi_writer`

## Requirements
- R1: Every frame carries exactly 24 bits. The first byte is the opcode 0x40, the second is the register address and the third is the value.
- R2: The bus uses mode 0 with the most significant bit first. `spi_sck` is low whenever no select is low. `spi_mosi` changes only while `spi_sck` is low, and the bench samples it on each rising edge of `spi_sck`.
- R3: `spi_cs_n[i]` goes low only for a frame addressed to expander `i` (binary index on `req_chip`), and at most one select is low at any time. That select stays low across all 24 bits, and it falls at least HALF_DIV system cycles before the first rising edge of `spi_sck`.
- R4: Between two frames, every select stays high for at least 2*HALF_DIV system cycles.
- R5: Inside a frame, consecutive rising edges of `spi_sck` are exactly 2*HALF_DIV system cycles apart.
- R6: Operation 0 (plain write) sends one frame with register `req_reg` and value `req_data[7:0]`.
- R7: Operation 1 (direction) sends register 0x00 and then register 0x01, each with value 0x00 when `req_data[0]` is 0 (drive) or 0xFF when it is 1 (float).
- R8: Operation 2 (address placement) sends register 0x12 with `req_data[15:8]`, then register 0x13 with `req_data[7:0]`.
- R9: Operation 3 (data placement) sends register 0x01 with 0x00, then register 0x13 with `req_data[7:0]`.
- R10: `req_ready` equals not `busy`. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle. A request presented while `busy` is high has no effect on the frames sent.
- R11: `done` is high for exactly one cycle after the last frame of a request, once its select is high again. `busy` is low in that same cycle, so a waiting request is taken in the `done` cycle.
- R12: While reset is held and just after it, every select is high, `spi_sck` and `spi_mosi` are low, `busy` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 plain write, 1 direction, 2 address placement, 3 data placement |
| req_chip | input | CHIP_W | Index of the target expander |
| req_reg | input | 8 | Register address for a plain write |
| req_data | input | 16 | Value or address word; bit 0 selects float for the direction operation |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the expanders |
| spi_cs_n | output | N_CHIPS | Active-low select, one per expander |

## Verification
Two things can happen in the same cycle: the `done` pulse that closes one request and the acceptance of the next request. The bench provokes this by holding `req_valid` high while a two-frame request is still running. It first offers a decoy request that must be ignored, then switches to the real follow-up. In the cycle `done` is seen, `req_ready` must already be high, and `busy` must be high in the next cycle. The serial monitor must then decode the follow-up frames, with full select gaps, right after the first request's frames and with no frame from the decoy.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;

   localparam int BYTE_W      = 8;
   localparam int FRAME_BYTES = 3;
   localparam int FRAME_W     = BYTE_W * FRAME_BYTES;

   localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h40;
   localparam logic [BYTE_W-1:0] REG_DIR_A = 8'h00;
   localparam logic [BYTE_W-1:0] REG_DIR_B = 8'h01;
   localparam logic [BYTE_W-1:0] REG_OUT_A = 8'h12;
   localparam logic [BYTE_W-1:0] REG_OUT_B = 8'h13;
   localparam logic [BYTE_W-1:0] DIR_DRIVE = 8'h00;
   localparam logic [BYTE_W-1:0] DIR_FLOAT = 8'hFF;

   typedef enum logic [1:0] {
      OP_RAW  = 2'd0,
      OP_DIR  = 2'd1,
      OP_ADDR = 2'd2,
      OP_DATA = 2'd3
   } op_e;

   typedef struct packed {
      logic [BYTE_W-1:0] reg_addr;
      logic [BYTE_W-1:0] value;
   } wr_t;

endpackage

// File: rtl/xpdr_plan.sv
module xpdr_plan
   import xpdr_pkg::*;
(
   input  logic [1:0]          op,
   input  logic [BYTE_W-1:0]   reg_in,
   input  logic [2*BYTE_W-1:0] data_in,
   output wr_t                 wr_first,
   output wr_t                 wr_second,
   output logic                two_frames
);

   logic [BYTE_W-1:0] dir_val;
   logic [BYTE_W-1:0] hi_byte;
   logic [BYTE_W-1:0] lo_byte;

   assign dir_val = data_in[0] ? DIR_FLOAT : DIR_DRIVE;
   assign hi_byte = data_in[2*BYTE_W-1:BYTE_W];
   assign lo_byte = data_in[BYTE_W-1:0];

   always_comb begin
      wr_first   = '{reg_addr: reg_in, value: lo_byte};
      wr_second  = '{reg_addr: reg_in, value: lo_byte};
      two_frames = 1'b0;
      unique case (op_e'(op))
         OP_RAW: begin
            two_frames = 1'b0;
         end
         OP_DIR: begin
            wr_first   = '{reg_addr: REG_DIR_A, value: dir_val};
            wr_second  = '{reg_addr: REG_DIR_B, value: dir_val};
            two_frames = 1'b1;
         end
         OP_ADDR: begin
            wr_first   = '{reg_addr: REG_OUT_A, value: hi_byte};
            wr_second  = '{reg_addr: REG_OUT_B, value: lo_byte};
            two_frames = 1'b1;
         end
         OP_DATA: begin
            wr_first   = '{reg_addr: REG_DIR_B, value: DIR_DRIVE};
            wr_second  = '{reg_addr: REG_OUT_B, value: lo_byte};
            two_frames = 1'b1;
         end
         default: begin
            two_frames = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/xpdr_seq.sv
module xpdr_seq
   import xpdr_pkg::*;
#(
   parameter int CHIP_W = 1
)
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [CHIP_W-1:0]  req_chip,
   input  wr_t                wr_first,
   input  wr_t                wr_second,
   input  logic               two_frames,
   input  logic               frame_done,
   output logic               busy,
   output logic               done,
   output logic               start,
   output logic [FRAME_W-1:0] frame,
   output logic [CHIP_W-1:0]  chip_q
);

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } sq_e;

   sq_e  st_q;
   wr_t  w0_q;
   wr_t  w1_q;
   logic two_q;
   logic slot_q;

   assign busy  = (st_q != SQ_IDLE);
   assign start = (st_q == SQ_ISSUE);
   assign frame = {OPC_WRITE, (slot_q ? w1_q : w0_q)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         w0_q   <= '0;
         w1_q   <= '0;
         two_q  <= 1'b0;
         slot_q <= 1'b0;
         chip_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (req_valid) begin
                  w0_q   <= wr_first;
                  w1_q   <= wr_second;
                  two_q  <= two_frames;
                  chip_q <= req_chip;
                  slot_q <= 1'b0;
                  st_q   <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               st_q <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (frame_done) begin
                  if (two_q && !slot_q) begin
                     slot_q <= 1'b1;
                     st_q   <= SQ_ISSUE;
                  end else begin
                     st_q <= SQ_IDLE;
                     done <= 1'b1;
                  end
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid)); // R10

endmodule

// File: rtl/xpdr_shift.sv
module xpdr_shift
   import xpdr_pkg::*;
#(
   parameter int HALF_DIV = 8
)
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               sck,
   output logic               mosi,
   output logic               sel_active,
   output logic               frame_done
);

   localparam int HC_W   = $clog2(2 * HALF_DIV) + 1;
   localparam int BC_W   = $clog2(FRAME_W);
   localparam int GAP_SAT = 2 * HALF_DIV;

   typedef enum logic [2:0] {
      SH_IDLE  = 3'd0,
      SH_LEAD  = 3'd1,
      SH_HIGH  = 3'd2,
      SH_LOW   = 3'd3,
      SH_TRAIL = 3'd4,
      SH_GAP   = 3'd5
   } sh_e;

   sh_e               st_q;
   logic [HC_W-1:0]   hc_q;
   logic [BC_W-1:0]   bitc_q;
   logic [FRAME_W-1:0] sh_q;
   logic              tick_half;
   logic              tick_full;

   generate
      if (HALF_DIV == 1) begin : g_tick_every
         assign tick_half = 1'b1;
      end else begin : g_tick_cnt
         assign tick_half = (hc_q == HC_W'(HALF_DIV - 1));
      end
   endgenerate

   assign tick_full = (hc_q == HC_W'(2 * HALF_DIV - 1));
   assign mosi      = sel_active & sh_q[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SH_IDLE;
         hc_q       <= '0;
         bitc_q     <= '0;
         sh_q       <= '0;
         sck        <= 1'b0;
         sel_active <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         unique case (st_q)
            SH_IDLE: begin
               if (start) begin
                  sh_q       <= frame;
                  sel_active <= 1'b1;
                  bitc_q     <= '0;
                  hc_q       <= '0;
                  st_q       <= SH_LEAD;
               end
            end
            SH_LEAD, SH_LOW: begin
               if (tick_half) begin
                  sck  <= 1'b1;
                  hc_q <= '0;
                  st_q <= SH_HIGH;
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            SH_HIGH: begin
               if (tick_half) begin
                  sck  <= 1'b0;
                  hc_q <= '0;
                  if (bitc_q == BC_W'(FRAME_W - 1)) begin
                     st_q <= SH_TRAIL;
                  end else begin
                     sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
                     bitc_q <= bitc_q + 1'b1;
                     st_q   <= SH_LOW;
                  end
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            SH_TRAIL: begin
               if (tick_half) begin
                  sel_active <= 1'b0;
                  hc_q       <= '0;
                  st_q       <= SH_GAP;
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            SH_GAP: begin
               if (tick_full) begin
                  hc_q       <= '0;
                  frame_done <= 1'b1;
                  st_q       <= SH_IDLE;
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            default: st_q <= SH_IDLE;
         endcase
      end
   end

   // checker state for the assertions below
   logic        sck_q;
   logic [7:0]  rise_cnt;
   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         rise_cnt <= '0;
         hi_cnt   <= GAP_SAT;
      end else begin
         sck_q <= sck;
         if (start && st_q == SH_IDLE) begin
            rise_cnt <= '0;
         end else if (sck && !sck_q) begin
            rise_cnt <= rise_cnt + 1'b1;
         end
         if (sel_active) begin
            hi_cnt <= 0;
         end else if (hi_cnt < GAP_SAT) begin
            hi_cnt <= hi_cnt + 1;
         end
      end
   end

   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi)); // R2

   AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (rise_cnt == 8'(FRAME_W))); // R1

   AST_SEL_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_active) |-> (hi_cnt >= GAP_SAT)); // R4

endmodule

// File: rtl/xpdr_spi_writer.sv
module xpdr_spi_writer
   import xpdr_pkg::*;
#(
   parameter int  N_CHIPS  = 2,
   parameter int  HALF_DIV = 8,
   localparam int CHIP_W   = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
)
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [1:0]          req_op,
   input  logic [CHIP_W-1:0]   req_chip,
   input  logic [7:0]          req_reg,
   input  logic [15:0]         req_data,
   output logic                busy,
   output logic                done,
   output logic                spi_sck,
   output logic                spi_mosi,
   output logic [N_CHIPS-1:0]  spi_cs_n
);

   generate
      if (N_CHIPS < 1) begin : g_bad_chips
         $error("xpdr_spi_writer: N_CHIPS must be at least 1");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("xpdr_spi_writer: HALF_DIV must be at least 1");
      end
   endgenerate

   wr_t                wr_first;
   wr_t                wr_second;
   logic               two_frames;
   logic               start;
   logic               frame_done;
   logic               sel_active;
   logic [FRAME_W-1:0] frame;
   logic [CHIP_W-1:0]  chip_q;

   assign req_ready = ~busy;

   xpdr_plan u_plan (
      .op         (req_op),
      .reg_in     (req_reg),
      .data_in    (req_data),
      .wr_first   (wr_first),
      .wr_second  (wr_second),
      .two_frames (two_frames)
   );

   xpdr_seq #(.CHIP_W(CHIP_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_chip   (req_chip),
      .wr_first   (wr_first),
      .wr_second  (wr_second),
      .two_frames (two_frames),
      .frame_done (frame_done),
      .busy       (busy),
      .done       (done),
      .start      (start),
      .frame      (frame),
      .chip_q     (chip_q)
   );

   xpdr_shift #(.HALF_DIV(HALF_DIV)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .frame      (frame),
      .sck        (spi_sck),
      .mosi       (spi_mosi),
      .sel_active (sel_active),
      .frame_done (frame_done)
   );

   generate
      for (genvar gi = 0; gi < N_CHIPS; gi++) begin : g_sel
         assign spi_cs_n[gi] = ~(sel_active && (chip_q == CHIP_W'(gi)));
      end
   endgenerate

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~spi_cs_n)); // R3

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (&spi_cs_n) |-> !spi_sck); // R2

   AST_DONE_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((&spi_cs_n) && !busy)); // R11

endmodule

// File: tb/xpdr_spi_writer_bench.sv
`timescale 1ns/1ps
module xpdr_spi_writer_bench;

   localparam int HALF = 4;
   localparam int NCH  = 3;
   localparam int CW   = 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            req_valid;
   logic            req_ready;
   logic [1:0]      req_op;
   logic [CW-1:0]   req_chip;
   logic [7:0]      req_reg;
   logic [15:0]     req_data;
   logic            busy;
   logic            done;
   logic            spi_sck;
   logic            spi_mosi;
   logic [NCH-1:0]  spi_cs_n;

   always #2.5 clk = ~clk;

   xpdr_spi_writer #(.N_CHIPS(NCH), .HALF_DIV(HALF)) u_xpdr_spi_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_chip(req_chip), .req_reg(req_reg), .req_data(req_data),
      .busy(busy), .done(done), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_cs_n(spi_cs_n)
   );

   int checks = 0;
   int fails  = 0;
   int issued = 0;
   int dones  = 0;
   bit finished = 0;

   logic [CW+23:0] expq[$];
   string          tagq[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input int chip, input logic [7:0] r, input logic [7:0] v,
                       input string tag);
      expq.push_back({CW'(chip), 8'h40, r, v});
      tagq.push_back(tag);
   endtask

   task automatic expect_req(input int op, input int chip, input logic [7:0] r,
                             input logic [15:0] d, input string tag);
      logic [7:0] dv;
      dv = d[0] ? 8'hFF : 8'h00;
      case (op)
         0: push(chip, r, d[7:0], tag);
         1: begin push(chip, 8'h00, dv, tag); push(chip, 8'h01, dv, tag); end
         2: begin push(chip, 8'h12, d[15:8], tag); push(chip, 8'h13, d[7:0], tag); end
         default: begin push(chip, 8'h01, 8'h00, tag); push(chip, 8'h13, d[7:0], tag); end
      endcase
   endtask

   task automatic drive(input int op, input int chip, input logic [7:0] r,
                        input logic [15:0] d);
      req_op   = 2'(op);
      req_chip = CW'(chip);
      req_reg  = r;
      req_data = d;
   endtask

   // driver: waits for ready, presents one request, confirms it was taken
   task automatic start_req(input int op, input int chip, input logic [7:0] r,
                            input logic [15:0] d, input string tag);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      expect_req(op, chip, r, d, tag);
      drive(op, chip, r, d);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      issued++;
      chk(busy && !req_ready, "R10", "busy after accept", {busy, req_ready}, 2'b10);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   // monitor: decodes frames at the serial pins and compares with the queue
   logic           prev_low = 1'b0;
   logic           prev_sck = 1'b0;
   logic           prev_mosi = 1'b0;
   logic           prev_done = 1'b0;
   logic           low;
   logic [NCH-1:0] cs_at_start;
   logic [23:0]    sh;
   logic [CW+23:0] exp_item;
   string          exp_tag;
   int gap_cnt = 1000;
   int since_rise, lead, nbits, cur_chip;
   bit per_bad, mosi_bad, cs_bad, idle_sck_bad;

   always @(negedge clk) begin
      if (rst_n) begin
         low = ~&spi_cs_n;
         if (!low && spi_sck) idle_sck_bad = 1;
         if (low && !prev_low) begin
            chk(gap_cnt >= 2*HALF, "R4", "select high gap", gap_cnt, 2*HALF);
            chk($countones(~spi_cs_n) == 1, "R3", "selects low at frame start",
                $countones(~spi_cs_n), 1);
            cs_at_start = spi_cs_n;
            cur_chip = 0;
            for (int i = 0; i < NCH; i++) if (!spi_cs_n[i]) cur_chip = i;
            nbits = 0; sh = '0; lead = 0; since_rise = 0;
            per_bad = 0; mosi_bad = 0; cs_bad = 0;
         end else if (low) begin
            if (spi_cs_n != cs_at_start) cs_bad = 1;
            since_rise++;
            if (nbits == 0) lead++;
            if (spi_sck && !prev_sck) begin
               if (nbits == 0)
                  chk(lead >= HALF, "R3", "select lead before first edge", lead, HALF);
               else if (since_rise != 2*HALF)
                  per_bad = 1;
               since_rise = 0;
               sh = {sh[22:0], spi_mosi};
               nbits++;
            end
            if (spi_sck && prev_sck && spi_mosi != prev_mosi) mosi_bad = 1;
         end
         if (!low && prev_low) begin
            chk(nbits == 24, "R1", "bits per frame", nbits, 24);
            chk(!per_bad, "R5", "sck period", per_bad, 0);
            chk(!mosi_bad, "R2", "mosi stable while sck high", mosi_bad, 0);
            chk(!cs_bad, "R3", "select steady in frame", cs_bad, 0);
            chk(!idle_sck_bad, "R2", "sck low while deselected", idle_sck_bad, 0);
            idle_sck_bad = 0;
            if (expq.size() == 0) begin
               chk(0, "R10", "unexpected frame", sh, 0);
            end else begin
               exp_item = expq.pop_front();
               exp_tag  = tagq.pop_front();
               chk(sh == exp_item[23:0], exp_tag, "frame content", sh, exp_item[23:0]);
               chk(cur_chip == int'(exp_item[CW+23:24]), "R3", "target select",
                   cur_chip, exp_item[CW+23:24]);
            end
            gap_cnt = 0;
         end
         if (!low) gap_cnt++;
         if (done) begin
            dones++;
            chk((&spi_cs_n) && !busy, "R11", "selects high and idle at done",
                {busy, spi_cs_n}, {1'b0, {NCH{1'b1}}});
            if (prev_done) chk(0, "R11", "done longer than one cycle", 2, 1);
         end
         prev_low  = low;
         prev_sck  = spi_sck;
         prev_mosi = spi_mosi;
         prev_done = done;
      end
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0;
      drive(0, 0, 8'h00, 16'h0000);
      repeat (3) @(negedge clk);
      chk(&spi_cs_n && !spi_sck && !spi_mosi && !busy && !done && req_ready, "R12",
          "outputs in reset", {spi_cs_n, spi_sck, spi_mosi, busy, done, req_ready},
          {{NCH{1'b1}}, 5'b00001});
      rst_n = 1'b1;
      @(negedge clk);
      chk(&spi_cs_n && !spi_sck && !busy && req_ready, "R12", "outputs after reset",
          {spi_cs_n, spi_sck, busy, req_ready}, {{NCH{1'b1}}, 3'b001});

      start_req(0, 0, 8'h0A, 16'h005C, "R6"); wait_done();
      start_req(0, 2, 8'h13, 16'h77A5, "R6"); wait_done();
      start_req(1, 1, 8'h00, 16'h0000, "R7"); wait_done();
      start_req(1, 1, 8'h00, 16'h0001, "R7"); wait_done();
      start_req(2, 0, 8'h00, 16'h1234, "R8"); wait_done();
      start_req(2, 0, 8'h00, 16'hFF00, "R8"); wait_done();
      start_req(3, 1, 8'h00, 16'h0081, "R9"); wait_done();

      // done and the next acceptance in one cycle, with a decoy while busy
      start_req(2, 0, 8'h00, 16'hBEEF, "R8");
      drive(0, 1, 8'h55, 16'h00AA);
      req_valid = 1'b1;
      repeat (40) @(negedge clk);
      chk(busy, "R10", "still busy with decoy offered", busy, 1);
      expect_req(3, 2, 8'h00, 16'h003C, "R9");
      drive(3, 2, 8'h00, 16'h003C);
      wait_done();
      chk(req_ready, "R11", "ready in done cycle", req_ready, 1);
      @(negedge clk);
      chk(busy, "R10", "request taken in done cycle", busy, 1);
      req_valid = 1'b0;
      issued++;
      wait_done();

      repeat (4 * HALF) @(negedge clk);
      chk(expq.size() == 0, "R10", "frames left unsent", expq.size(), 0);
      chk(dones == issued, "R11", "done pulses per request", dones, issued);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", 100000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule